// File: doc/BRIEF.md
# SPI Serial Clock Generator with Two-Stage Divider

This block turns the peripheral clock into the serial clock of an SPI controller. Two divider stages run in cascade. The first is an even prescaler. The second is a rate divider that counts the prescaler's ticks. The serial clock period is `prescale * (1 + rate)` peripheral clock cycles. A restriction to even prescale values means each half of that period is a whole number of cycles, `(prescale/2) * (1 + rate)`.

Alongside the pin level, the generator produces two single-cycle strobes for the shift engine: launch, which drives the next data bit out, and capture, which samples the incoming bit. Clock polarity sets the idle level. Clock phase sets which edge of each bit captures and which launches, giving all four SPI modes. The generator is held idle while its enable is low. Raising the enable starts a fresh count from zero.

Top module: `spi_sclk_gen`

## Requirements
- R1: While `rst_n` is low or `enable` is low, `sclk` equals `cpol` and both `launch` and `capture` are 0.
- R2: With the divider half-count H = (P/2)*(rate+1), where P is the effective prescale, `sclk` changes level in the cycle after the H-th, 2H-th, 3H-th ... rising clock edge at which `enable` was sampled high.
- R3: Bit 0 of `prescale` is ignored, so an odd value 2k+1 divides exactly as 2k does.
- R4: An effective prescale of 0 (input 0 or 1) is treated as 2.
- R5: At prescale 2 and rate 0, `sclk` toggles every input clock cycle, which is half the input clock rate.
- R6: At prescale 254 and rate 255, one `sclk` level lasts 32512 input clock cycles, which is 1/(254*256) of the input rate for a full period.
- R7: With `cpha` = 0, `capture` accompanies the leading edge, the one leaving the idle level, and `launch` accompanies the trailing edge. With `cpha` = 1 the two are swapped.
- R8: `launch` and `capture` are never high together. Each is high for exactly one cycle, and that is the cycle in which `sclk` takes its new level.
- R9: Dropping `enable` in the middle of a bit returns `sclk` to `cpol` in the same cycle. The next rise of `enable` restarts the count with a leading edge H cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds it idle and clears its counters |
| prescale | input | PRE_W (8) | Prescale value; bit 0 ignored, 0 acts as 2 |
| rate | input | RATE_W (8) | Rate divider value; the period is multiplied by rate+1 |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| sclk | output | 1 | Serial clock pin level |
| launch | output | 1 | One-cycle strobe: drive next bit out |
| capture | output | 1 | One-cycle strobe: sample incoming bit |

## Verification
The bench builds the generator with its default widths of 8 bits for prescale and 8 bits for rate. These are the widths needed to reach both ends of the range: the fastest setting, which toggles every cycle, and the slowest, prescale 254 with rate 255, whose 32512-cycle half period fits within the run. The default widths also give odd and zero prescale values their own runs. Every combination of polarity and phase is driven, and `enable` is dropped mid-bit and raised again to show that the count restarts from zero.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;

   // Which serial clock edge comes next within the current bit
   typedef enum logic {
      EDGE_LEADING  = 1'b0,
      EDGE_TRAILING = 1'b1
   } edge_kind_e;

   // Strobes handed to the shift engine
   typedef struct packed {
      logic launch;
      logic capture;
   } strobe_t;

endpackage

// File: rtl/spi_clkgen_prescale.sv
// First divider stage: one tick every half-prescale cycles while running.
module spi_clkgen_prescale #(
   parameter int HW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [HW-1:0] half_ps,
   output logic          tick
);

   generate
      if (HW == 1) begin : g_direct
         // Half-count is always 1: a tick on every running cycle
         logic unused_half;
         assign unused_half = ^half_ps;
         assign tick = run;
      end else begin : g_count
         logic [HW-1:0] cnt_q;
         logic [HW-1:0] half_eff;
         logic [HW-1:0] lim;

         assign half_eff = (half_ps == '0) ? HW'(1) : half_ps;
         assign lim      = half_eff - HW'(1);
         assign tick     = run & (cnt_q >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || tick) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + HW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/spi_clkgen_rate.sv
// Second divider stage: wraps after rate+1 prescaler ticks.
module spi_clkgen_rate #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate,
   output logic              wrap
);

   logic [RATE_W-1:0] cnt_q;

   assign wrap = tick & (cnt_q >= rate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= wrap ? '0 : cnt_q + RATE_W'(1);
      end
   end

endmodule

// File: rtl/spi_clkgen_edge.sv
// Edge tracker: alternates leading/trailing edges and issues the strobes.
module spi_clkgen_edge
   import spi_clkgen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       toggle,
   input  logic       cpha,
   output edge_kind_e next_edge,
   output strobe_t    strobe
);

   edge_kind_e edge_q;
   logic       on_trailing;
   logic       cap_now;

   assign on_trailing = (edge_q == EDGE_TRAILING);
   // phase 0 samples on leading edges, phase 1 on trailing edges
   assign cap_now     = (on_trailing == cpha);
   assign next_edge   = edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q <= EDGE_LEADING;
         strobe <= '0;
      end else if (!run) begin
         edge_q <= EDGE_LEADING;
         strobe <= '0;
      end else begin
         strobe.capture <= toggle & cap_now;
         strobe.launch  <= toggle & ~cap_now;
         if (toggle) begin
            edge_q <= on_trailing ? EDGE_LEADING : EDGE_TRAILING;
         end
      end
   end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
   import spi_clkgen_pkg::*;
#(
   parameter int PRE_W  = 8,
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [PRE_W-1:0]  prescale,
   input  logic [RATE_W-1:0] rate,
   input  logic              cpol,
   input  logic              cpha,
   output logic              sclk,
   output logic              launch,
   output logic              capture
);

   localparam int HW = PRE_W - 1;

   generate
      if (PRE_W < 2) begin : g_bad_pre_w
         $error("spi_sclk_gen: PRE_W must be at least 2");
      end
      if (RATE_W < 1) begin : g_bad_rate_w
         $error("spi_sclk_gen: RATE_W must be at least 1");
      end
   endgenerate

   logic       unused_ps_lsb;
   logic       pre_tick;
   logic       rate_wrap;
   edge_kind_e next_edge;
   strobe_t    strobe;

   // the prescale is even by definition: its low bit carries no weight
   assign unused_ps_lsb = prescale[0];

   spi_clkgen_prescale #(.HW(HW)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (enable),
      .half_ps (prescale[PRE_W-1:1]),
      .tick    (pre_tick)
   );

   spi_clkgen_rate #(.RATE_W(RATE_W)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (enable),
      .tick  (pre_tick),
      .rate  (rate),
      .wrap  (rate_wrap)
   );

   spi_clkgen_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (enable),
      .toggle    (rate_wrap),
      .cpha      (cpha),
      .next_edge (next_edge),
      .strobe    (strobe)
   );

   // after a leading edge the pin sits away from idle until the trailing one
   assign sclk    = cpol ^ (enable & (next_edge == EDGE_TRAILING));
   assign launch  = enable & strobe.launch;
   assign capture = enable & strobe.capture;

endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
   parameter int PRE_W  = 8,
   parameter int RATE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [PRE_W-1:0]  prescale,
   input logic [RATE_W-1:0] rate,
   input logic              cpol,
   input logic              cpha,
   input logic              sclk,
   input logic              launch,
   input logic              capture
);

   localparam int CW = PRE_W + RATE_W;

   logic [PRE_W-2:0] half;
   logic [CW-1:0]    hexp;
   logic [CW-1:0]    cnt_q;
   logic             past_ok;
   logic             strobe;

   assign half   = (prescale[PRE_W-1:1] == '0) ? (PRE_W-1)'(1) : prescale[PRE_W-1:1];
   assign hexp   = CW'(half) * (CW'(rate) + CW'(1));
   assign strobe = launch | capture;

   // enabled edges since the last strobe or the rise of enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
         if (!enable)     cnt_q <= '0;
         else if (strobe) cnt_q <= CW'(1);
         else             cnt_q <= cnt_q + CW'(1);
      end
   end

   // R1
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (sclk == cpol) && !launch && !capture);

   // R8
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({launch, capture}));

   // R8
   a_r8_strobe_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && strobe && $stable(cpol)) |-> !$stable(sclk));

   // R8
   a_r8_edge_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && enable && $past(enable) && $stable(cpol) && !$stable(sclk)) |-> strobe);

   // R7
   a_r7_capture_side: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> ((sclk != cpol) == !cpha));

   // R7
   a_r7_launch_side: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> ((sclk != cpol) == cpha));

   // R2
   a_r2_interval: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && strobe && $stable(prescale) && $stable(rate)) |-> (cnt_q == hexp));

   // R2
   a_r2_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && enable && $stable(prescale) && $stable(rate)) |-> (cnt_q <= hexp));

endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .prescale (prescale),
   .rate     (rate),
   .cpol     (cpol),
   .cpha     (cpha),
   .sclk     (sclk),
   .launch   (launch),
   .capture  (capture)
);

// File: tb/spi_sclk_gen_tb.sv
`timescale 1ns/1ps
module spi_sclk_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] ps = 8'd2;
   logic [7:0] rt = 8'd0;
   logic       pol = 1'b0;
   logic       pha = 1'b0;
   logic       sclk, launch, capture;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   bit    done = 1'b0;
   int    strobe_seen = 0;

   // reference model state
   int m_cnt = 0;
   bit m_ph = 1'b0;
   bit m_l = 1'b0;
   bit m_c = 1'b0;

   always #4 clk = ~clk;

   spi_sclk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .enable(en), .prescale(ps), .rate(rt),
      .cpol(pol), .cpha(pha), .sclk(sclk), .launch(launch), .capture(capture)
   );

   function automatic int half_count(input int p, input int r);
      int pe;
      pe = p - (p % 2);
      if (pe == 0) pe = 2;
      return (pe / 2) * (r + 1);
   endfunction

   // behavioural reference: one counter of enabled edges
   always @(posedge clk) begin
      if (!rst_n || !en) begin
         m_cnt = 0; m_ph = 1'b0; m_l = 1'b0; m_c = 1'b0;
      end else begin
         m_cnt = m_cnt + 1;
         m_l = 1'b0; m_c = 1'b0;
         if (m_cnt >= half_count(ps, rt)) begin
            m_cnt = 0;
            // leading edge when m_ph is 0; phase 0 captures there
            m_c = ((m_ph == 1'b0) != pha);
            m_l = !m_c;
            m_ph = !m_ph;
         end
      end
   end

   always @(negedge clk) begin
      bit e_s, e_l, e_c;
      if (!done) begin
         e_s = pol ^ (m_ph & en);
         e_l = m_l & en;
         e_c = m_c & en;
         checks++;
         if (sclk !== e_s || launch !== e_l || capture !== e_c) begin
            failures++;
            $display("FAIL %s t=%0t sclk/launch/capture actual=%b%b%b expected=%b%b%b",
                     cur_req, $time, sclk, launch, capture, e_s, e_l, e_c);
         end
         if (launch === 1'b1 || capture === 1'b1) strobe_seen++;
      end
   end

   task automatic check_val(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_cfg(input string req, input int p, input int r,
                          input bit cp, input bit ph, input int n);
      @(posedge clk); #1;
      en = 1'b0; ps = p[7:0]; rt = r[7:0]; pol = cp; pha = ph; cur_req = req;
      repeat (2) @(posedge clk);
      #1;
      strobe_seen = 0;
      en = 1'b1;
      repeat (n) @(posedge clk);
      #1;
      en = 1'b0;
      // strobe count within the run (R2 interval rule)
      check_val({req, "/R2 strobe count"}, strobe_seen, (n - 1) / half_count(p, r));
   endtask

   initial begin
      // R1: reset with idle high polarity
      pol = 1'b1;
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1;
      // R1: disabled, both polarities
      repeat (4) @(posedge clk);
      #1; pol = 1'b0; ps = 8'd6; rt = 8'd3;
      repeat (4) @(posedge clk);
      run_cfg("R5", 2, 0, 1'b0, 1'b0, 21);
      run_cfg("R2", 6, 2, 1'b1, 1'b1, 100);
      run_cfg("R3", 7, 1, 1'b0, 1'b1, 40);
      run_cfg("R4", 0, 3, 1'b1, 1'b0, 30);
      run_cfg("R4", 1, 2, 1'b0, 1'b0, 25);
      // R7: all four modes
      run_cfg("R7", 4, 0, 1'b0, 1'b0, 17);
      run_cfg("R7", 4, 0, 1'b0, 1'b1, 17);
      run_cfg("R7", 4, 0, 1'b1, 1'b0, 17);
      run_cfg("R7", 4, 0, 1'b1, 1'b1, 17);
      // R9: drop mid-bit then restart
      run_cfg("R9", 4, 4, 1'b0, 1'b0, 13);
      run_cfg("R9", 4, 4, 1'b0, 1'b0, 25);
      run_cfg("R8", 10, 7, 1'b1, 1'b1, 200);
      run_cfg("R6", 254, 255, 1'b0, 1'b0, 65100);
      repeat (3) @(posedge clk);
      #1;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule